// File: doc/BRIEF.md
# Carry-Save Transposed FIR Filter

This block is a fixed-coefficient FIR filter in transposed direct form, built for high sample rates. Each accepted input sample is scaled by every coefficient in the same cycle, with no hardware multipliers. Every coefficient is recoded at elaboration into signed power-of-two digits in non-adjacent form, and each non-zero digit becomes one carry-save adder stage. The partial sum held between two taps is never resolved. It is stored as a redundant pair of words, one for sum and one for carry, and it enters the next tap as the seed of that tap's carry-save chain. One registered merging adder after the last tap turns the result into an ordinary two's-complement word.

The sample input and the filtered output are valid/ready streams. The whole datapath advances together. When the output holds a result that the consumer has not taken, the filter stalls, holds its output and drops in_ready. A cycle with no accepted sample is a bubble. It passes down the output pipeline and leaves the tap history untouched. All internal words share one width, W = DW + CW + ceil(log2(TAPS)), and every addition wraps modulo 2^W. A carry-save pair therefore never has to be sign-extended, and the carry word never grows.

Top module: `fir_cs_transposed`

## Requirements
- R1: A sample is taken on a rising clock edge only when in_valid and in_ready are both high at that edge.
- R2: For accepted samples x[n], out_data is the signed value sum over k of COEF[k]*x[n-k], reduced to W bits (W = 19 with the default DW = 8, CW = 8, TAPS = 6). Results appear in the order the samples were accepted.
- R3: Each tap produces a sum/carry pair whose total modulo 2^W equals the incoming pair plus COEF[k] times the sign-extended sample. No carry is propagated between taps.
- R4: With out_ready held high, the result of a sample accepted at edge e is shown with out_valid high just after edge e+1, and not before.
- R5: While out_valid is high and out_ready is low, out_valid and out_data hold their values on the next edge, and in_ready is low.
- R6: in_ready is high whenever out_valid is low or out_ready is high.
- R7: Synchronous active-high rst clears out_valid and all sum, carry and output registers. After reset, results treat every sample from before the reset as zero.
- R8: A cycle with no accepted sample does not change the tap history. Idle gaps of any length give the same results as back-to-back samples.
- R9: Full-scale inputs (-128 and 127 with DW = 8) against the extreme coefficients 127 and -128 give exact results.
- R10: A single 1 followed by zeros produces the coefficients as consecutive outputs, COEF[0] first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Filter can take a sample this cycle |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Filtered result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | W | Signed filtered result, W = DW+CW+ceil(log2(TAPS)) |

## Verification
The hardest case to reach is a stall that lands while the output pipeline holds a bubble between two samples. In that case a history shift that is wrongly gated, or a bubble that is lost, only shows up many samples later. The stimulus therefore runs idle gaps of random length on the input side while out_ready toggles at random, and a reference convolution checks every result. Full-scale alternating samples drive the negative-digit injection in the carry word through its extremes, and a reset in the middle of a run shows that the history is cleared.

// File: rtl/fir_cs_pkg.sv
package fir_cs_pkg;

  // Signed digit (-1, 0, +1) at position pos of the non-adjacent-form
  // recoding of value; evaluated at elaboration only.
  function automatic int naf_digit(input int value, input int pos);
    int v;
    int d;
    v = value;
    d = 0;
    for (int j = 0; j <= pos; j++) begin
      if (v[0]) d = v[1] ? -1 : 1;
      else      d = 0;
      v = (v - d) >>> 1;
    end
    return d;
  endfunction

endpackage

// File: rtl/fir_cs_cmac.sv
// Constant multiply-accumulate in carry-save form:
// (acc_s + acc_c) == (seed_s + seed_c) + COEF * x   (mod 2^W)
module fir_cs_cmac
  import fir_cs_pkg::*;
#(
  parameter int DW   = 8,
  parameter int W    = 19,
  parameter int COEF = 1,
  parameter int NDIG = 9
) (
  input  logic signed [DW-1:0] x,
  input  logic [W-1:0]         seed_s,
  input  logic [W-1:0]         seed_c,
  output logic [W-1:0]         acc_s,
  output logic [W-1:0]         acc_c
);

  logic [W-1:0] xe;
  logic [W-1:0] s_q [NDIG+1];
  logic [W-1:0] c_q [NDIG+1];

  assign xe     = {{(W-DW){x[DW-1]}}, x};
  assign s_q[0] = seed_s;
  assign c_q[0] = seed_c;

  for (genvar i = 0; i < NDIG; i++) begin : g_digit
    localparam int DIG = naf_digit(COEF, i);
    if (DIG == 0) begin : g_skip
      assign s_q[i+1] = s_q[i];
      assign c_q[i+1] = c_q[i];
    end else begin : g_csa
      // a negative digit adds ~term here and its +1 in the free carry LSB
      localparam logic [W-1:0] INJ = (DIG < 0) ? W'(1) : '0;
      logic [W-1:0] term;
      logic [W-1:0] maj;
      assign term     = (DIG > 0) ? (xe << i) : ~(xe << i);
      assign maj      = (s_q[i] & c_q[i]) | (s_q[i] & term) | (c_q[i] & term);
      assign s_q[i+1] = s_q[i] ^ c_q[i] ^ term;
      assign c_q[i+1] = (maj << 1) | INJ;
    end
  end

  assign acc_s = s_q[NDIG];
  assign acc_c = c_q[NDIG];

  always_comb begin
    AST_TAP_CONGRUENT: assert (W'(acc_s + acc_c) == W'(seed_s + seed_c + xe * W'(COEF))); // R3
  end

endmodule

// File: rtl/fir_cs_merge.sv
// Registered vector merging adder: resolves the carry-save pair once.
module fir_cs_merge #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         pair_vld,
  input  logic [W-1:0] pair_s,
  input  logic [W-1:0] pair_c,
  output logic         res_vld,
  output logic [W-1:0] res
);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      res     <= '0;
    end else if (adv) begin
      res_vld <= pair_vld;
      if (pair_vld) res <= pair_s + pair_c;
    end
  end

endmodule

// File: rtl/fir_cs_transposed.sv
module fir_cs_transposed #(
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int TAPS = 6,
  parameter logic signed [CW-1:0] COEF [TAPS] =
    '{8'sd41, -8'sd55, 8'sd79, 8'sd127, -8'sd128, 8'sd3},
  localparam int GW = $clog2(TAPS),
  localparam int W  = DW + CW + GW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [W-1:0]  out_data
);

  localparam int NDIG = CW + 1;

  logic adv;
  logic take;

  // carry-save registers between taps: r_*[k] feeds tap k
  logic [W-1:0] r_s [TAPS-1];
  logic [W-1:0] r_c [TAPS-1];
  logic [W-1:0] p_s [TAPS];
  logic [W-1:0] p_c [TAPS];

  logic         v1;
  logic [W-1:0] s1;
  logic [W-1:0] c1;
  logic [W-1:0] merged;

  assign adv      = !(out_valid && !out_ready);
  assign in_ready = adv;
  assign take     = in_valid && adv;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic [W-1:0] seed_s;
    logic [W-1:0] seed_c;
    if (k == TAPS-1) begin : g_last
      assign seed_s = '0;
      assign seed_c = '0;
    end else begin : g_mid
      assign seed_s = r_s[k];
      assign seed_c = r_c[k];
    end

    fir_cs_cmac #(
      .DW  (DW),
      .W   (W),
      .COEF(int'(COEF[k])),
      .NDIG(NDIG)
    ) u_cmac (
      .x     (in_data),
      .seed_s(seed_s),
      .seed_c(seed_c),
      .acc_s (p_s[k]),
      .acc_c (p_c[k])
    );

    if (k > 0) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          r_s[k-1] <= '0;
          r_c[k-1] <= '0;
        end else if (take) begin
          r_s[k-1] <= p_s[k];
          r_c[k-1] <= p_c[k];
        end
      end
    end
  end

  // first output stage keeps the tap-0 result in carry-save form
  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      s1 <= '0;
      c1 <= '0;
    end else if (adv) begin
      v1 <= in_valid;
      if (in_valid) begin
        s1 <= p_s[0];
        c1 <= p_c[0];
      end
    end
  end

  fir_cs_merge #(.W(W)) u_merge (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .pair_vld(v1),
    .pair_s  (s1),
    .pair_c  (c1),
    .res_vld (out_valid),
    .res     (merged)
  );

  assign out_data = signed'(merged);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R5

  AST_READY_FREE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready); // R6

  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(v1)); // R4

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(r_s[0]) && $stable(r_c[0]))); // R8

endmodule

// File: tb/tb_fir_cs_transposed.sv
`timescale 1ns/1ps
module tb_fir_cs_transposed;

  localparam int DW   = 8;
  localparam int CW   = 8;
  localparam int TAPS = 6;
  localparam int W    = DW + CW + $clog2(TAPS);
  localparam int H [TAPS] = '{41, -55, 79, 127, -128, 3};

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [DW-1:0] in_data = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b1;
  logic signed [W-1:0]  out_data;

  int checks = 0;
  int fails  = 0;
  bit bp_en  = 1'b0;
  bit done   = 1'b0;

  logic signed [W-1:0] q [$];
  int hist [TAPS];

  always #2 clk = ~clk;

  fir_cs_transposed #(.DW(DW), .CW(CW), .TAPS(TAPS)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference convolution, pushed at acceptance (R1, R2)
  task automatic push_expected(input int x);
    longint acc;
    logic [W-1:0] tr;
    for (int k = TAPS-1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    acc = 0;
    for (int k = 0; k < TAPS; k++) acc += longint'(H[k]) * longint'(hist[k]);
    tr = acc[W-1:0];
    q.push_back(signed'(tr));
  endtask

  // driver: called at a falling edge
  task automatic send(input int x);
    in_valid = 1'b1;
    in_data  = x[DW-1:0];
    while (!in_ready) @(negedge clk);
    push_expected(x);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() != 0 || out_valid) @(negedge clk);
  endtask

  // consumer back-pressure, changed just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1 out_ready = bp_en ? 1'($urandom_range(0, 1)) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit held = 1'b0;
    logic signed [W-1:0] hv;
    forever begin
      @(negedge clk);
      if (rst) begin
        held = 1'b0;
      end else begin
        if (held) chk(out_valid && out_data == hv, "R5 hold", out_data, hv);
        held = 1'b0;
        if (!out_valid || out_ready) chk(in_ready == 1'b1, "R6 ready", in_ready, 1);
        if (out_valid && !out_ready) begin
          chk(in_ready == 1'b0, "R5 ready low", in_ready, 0);
          held = 1'b1;
          hv   = out_data;
        end
        if (out_valid && out_ready) begin
          if (q.size() == 0) chk(1'b0, "R2 unexpected output", out_data, 0);
          else begin
            logic signed [W-1:0] e;
            e = q.pop_front();
            chk(out_data == e, "R2 value", out_data, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state
    chk(out_valid == 1'b0, "R7 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R7 in_ready", in_ready, 1);

    // R10: impulse reproduces the coefficients, COEF[0] first
    send(1);
    for (int i = 0; i < TAPS; i++) send(0);
    drain();

    // R4: latency with out_ready high
    in_valid = 1'b1; in_data = 8'sd5;
    push_expected(5);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R4 early", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R4 on time", out_valid, 1);
    drain();

    // R9: full-scale corners
    for (int i = 0; i < 12; i++) send((i % 2) ? 127 : -128);
    for (int i = 0; i < 8; i++) send(-128);
    drain();

    // R2: random back-to-back samples
    for (int i = 0; i < 200; i++) send($urandom_range(0, 255) - 128);
    drain();

    // R8: random idle gaps between samples
    for (int i = 0; i < 150; i++) begin
      send($urandom_range(0, 255) - 128);
      idle($urandom_range(0, 4));
    end
    drain();

    // R5/R6: random back-pressure, with and without gaps
    bp_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      send($urandom_range(0, 255) - 128);
      if (i % 3 == 0) idle($urandom_range(0, 3));
    end
    drain();
    bp_en = 1'b0;
    idle(2);

    // R7: reset mid-run clears history
    for (int i = 0; i < 4; i++) send(100 - 30 * i);
    drain();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 after reset", out_valid, 0);
    send(1);
    for (int i = 0; i < TAPS; i++) send(0);
    drain();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule